// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a 32-bit bus master and a word-organised target memory or register space. Two target regions each get an alias window. In that window every target bit owns one 32-bit alias word. A master that writes an alias word changes exactly one target bit. The bridge does this with a locked read-modify-write on the target. A master that reads an alias word gets that single bit back as 0 or 1. Addresses outside both alias windows go straight through to the target.

Every master request is one transaction. The master raises `m_valid` with its address, direction, size and write data, and holds them. The bridge answers with a one-cycle `m_ready` pulse that carries `m_rdata` and `m_err`. The target side works the same way: the bridge holds `t_valid` and its fields until the target raises `t_ready`. Read data is taken in that same cycle.

The data lanes are little-endian within a 32-bit word, and `t_rdata`/`t_wdata` always carry the whole word. While the two halves of a read-modify-write are in progress, `t_lock` tells the interconnect to admit no other master between them.

Top module: `bb_bridge`

## Requirements
- R1: An address outside both alias windows is passed to the target unchanged: address, direction, size code and write data. A passthrough read returns the target word on `m_rdata`. A passthrough write returns 0.
- R2: The alias windows are [0x2200_0000, 0x2400_0000) for the region based at 0x2000_0000 and [0x4200_0000, 0x4400_0000) for the region based at 0x4000_0000. Alias address base + 0x0200_0000 + o*32 + b*4 selects bit b (0..7) of the target byte at offset o. That is bit o[1:0]*8+b of the word-lane data, with `t_addr` = base+o.
- R3: An alias write sets the target bit when `m_wdata[0]` is 1 and clears it when `m_wdata[0]` is 0. Bits 31..1 of `m_wdata` have no effect.
- R4: An alias write leaves every other bit of the target location unchanged.
- R5: An alias read returns the addressed bit in `m_rdata[0]` with bits 31..1 zero, and makes no target write.
- R6: An alias write is a target read followed directly by a target write to the same address. `t_lock` is high through both, and no other target handshake lies between them.
- R7: The size code (0 byte, 1 halfword, 2 word) of an alias access appears unchanged on `t_size`. `t_addr` is aligned down to that size (halfword clears bit 0, word clears bits 1..0).
- R8: An alias address whose byte offset is at or beyond its region's size (0x8000 for the first region, 0x10_0000 for the second) returns `m_err`=1 with `m_rdata`=0 and makes no target access.
- R9: Each request gets exactly one `m_ready` pulse, one cycle wide. Target wait states only delay it, and the bridge holds `t_valid` and `t_addr` stable while `t_ready` is low.
- R10: During and straight after reset, `m_ready`, `m_err`, `t_valid` and `t_lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| m_valid | input | 1 | Master request held until `m_ready` |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | 32 | Master byte address |
| m_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| m_wdata | input | 32 | Master write data, word lanes |
| m_ready | output | 1 | One-cycle response strobe |
| m_rdata | output | 32 | Response read data, valid with `m_ready` |
| m_err | output | 1 | Response error flag, valid with `m_ready` |
| t_valid | output | 1 | Target request |
| t_write | output | 1 | Target direction |
| t_lock | output | 1 | High across both halves of a read-modify-write |
| t_addr | output | 32 | Target byte address |
| t_size | output | 2 | Target size code |
| t_wdata | output | 32 | Target write data, word lanes |
| t_ready | input | 1 | Target completes the request this cycle |
| t_rdata | input | 32 | Target read data, valid with `t_ready` |

## Verification
Some behaviours are checked on every cycle by the assertions. A locked write always comes straight after a locked read of the same address. That write word differs from the word just read in at most one bit, and that bit holds the written value. `m_ready` never lasts two cycles. An error response carries zero data and follows a cycle with no target request. An alias read answer has nothing above bit 0. Target requests hold steady while `t_ready` is low.

Other behaviours can only be shown by the bench scenarios against its own shadow memory. These are the address arithmetic for each region, each size and each bit position; the ignored upper write bits; the out-of-region error leaving memory untouched; and correct results when the target inserts wait states.

// File: rtl/bb_pkg.sv
package bb_pkg;

  localparam int unsigned BB_AW = 32;
  localparam int unsigned BB_DW = 32;
  localparam int unsigned BB_BW = $clog2(BB_DW);

  // Size codes on m_size / t_size
  localparam logic [1:0] BB_SZ_BYTE = 2'd0;
  localparam logic [1:0] BB_SZ_HALF = 2'd1;
  localparam logic [1:0] BB_SZ_WORD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PASS = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_RESP = 3'd4
  } bb_state_e;

endpackage

// File: rtl/bb_rst_sync.sv
module bb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/bb_region_dec.sv
module bb_region_dec #(
  parameter int unsigned AW         = 32,
  parameter int unsigned BW         = 5,
  parameter logic [31:0] BASE       = 32'h2000_0000,
  parameter logic [31:0] SIZE       = 32'h0000_8000,
  parameter logic [31:0] ALIAS_OFS  = 32'h0200_0000,
  parameter logic [31:0] ALIAS_SPAN = 32'h0200_0000
) (
  input  logic [AW-3:0] addr_w,
  input  logic [1:0]    size,
  output logic          hit,
  output logic          err,
  output logic [AW-1:0] taddr,
  output logic [BW-1:0] bitpos
);

  localparam logic [31:0]   WIN_BYTE = BASE + ALIAS_OFS;
  localparam logic [AW-3:0] WIN_W    = WIN_BYTE[AW-1:2];
  localparam logic [AW-3:0] SPAN_W   = ALIAS_SPAN[AW-1:2];

  logic [AW-3:0] off_w;
  logic [AW-6:0] byte_off;
  logic          in_win;
  logic [AW-1:0] raw_addr;

  always_comb begin
    off_w    = addr_w - WIN_W;
    in_win   = (addr_w >= WIN_W) && (off_w < SPAN_W);
    byte_off = off_w[AW-3:3];
    hit      = in_win && ({5'd0, byte_off} < SIZE);
    err      = in_win && ({5'd0, byte_off} >= SIZE);
    raw_addr = BASE + {5'd0, byte_off};
    bitpos   = {byte_off[1:0], off_w[2:0]};
    unique case (size)
      2'd2:    taddr = {raw_addr[AW-1:2], 2'b00};
      2'd1:    taddr = {raw_addr[AW-1:1], 1'b0};
      default: taddr = raw_addr;
    endcase
  end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int unsigned DW = 32,
  parameter int unsigned BW = $clog2(DW)
) (
  input  logic [DW-1:0] rword,
  input  logic [BW-1:0] bitpos,
  input  logic          wbit,
  output logic [DW-1:0] mword,
  output logic          rbit
);

  for (genvar i = 0; i < DW; i++) begin : g_lane
    assign mword[i] = (bitpos == BW'(i)) ? wbit : rword[i];
  end

  assign rbit = rword[bitpos];

endmodule

// File: rtl/bb_rmw_seq.sv
module bb_rmw_seq
  import bb_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_valid,
  input  logic          m_write,
  input  logic [AW-1:0] m_addr,
  input  logic [1:0]    m_size,
  input  logic [DW-1:0] m_wdata,
  input  logic          dec_hit,
  input  logic          dec_err,
  input  logic [AW-1:0] dec_taddr,
  input  logic [BW-1:0] dec_bitpos,
  input  logic          t_ready,
  input  logic [DW-1:0] t_rdata,
  input  logic [DW-1:0] mrg_word,
  input  logic          mrg_bit,
  output logic          t_valid,
  output logic          t_write,
  output logic          t_lock,
  output logic [AW-1:0] t_addr,
  output logic [1:0]    t_size,
  output logic [DW-1:0] t_wdata,
  output logic          m_ready,
  output logic [DW-1:0] m_rdata,
  output logic          m_err,
  output logic [BW-1:0] sel_bitpos,
  output logic          sel_wbit,
  output logic [DW-1:0] held_word
);

  bb_state_e     state_q, state_d;
  logic          ld_req, ld_rdata, ld_merge;
  logic [DW-1:0] rdata_d;

  logic          write_q, alias_q, err_q, wbit_q;
  logic [1:0]    size_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, held_q;
  logic [BW-1:0] bitpos_q;

  // next-state and enables
  always_comb begin
    state_d  = state_q;
    ld_req   = 1'b0;
    ld_rdata = 1'b0;
    ld_merge = 1'b0;
    rdata_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (m_valid) begin
          ld_req = 1'b1;
          if (dec_err) begin
            ld_rdata = 1'b1;
            state_d  = ST_RESP;
          end else if (dec_hit) begin
            state_d = ST_RD;
          end else begin
            state_d = ST_PASS;
          end
        end
      end
      ST_PASS: begin
        if (t_ready) begin
          ld_rdata = 1'b1;
          rdata_d  = write_q ? '0 : t_rdata;
          state_d  = ST_RESP;
        end
      end
      ST_RD: begin
        if (t_ready) begin
          ld_merge = 1'b1;
          ld_rdata = 1'b1;
          if (write_q) begin
            state_d = ST_WR;
          end else begin
            rdata_d = {{(DW-1){1'b0}}, mrg_bit};
            state_d = ST_RESP;
          end
        end
      end
      ST_WR: begin
        if (t_ready) state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      write_q  <= 1'b0;
      alias_q  <= 1'b0;
      err_q    <= 1'b0;
      wbit_q   <= 1'b0;
      size_q   <= 2'd0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      held_q   <= '0;
      bitpos_q <= '0;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        write_q  <= m_write;
        alias_q  <= dec_hit;
        err_q    <= dec_err;
        wbit_q   <= m_wdata[0];
        size_q   <= m_size;
        addr_q   <= (dec_hit || dec_err) ? dec_taddr : m_addr;
        wdata_q  <= m_wdata;
        bitpos_q <= dec_bitpos;
      end else if (ld_merge && write_q) begin
        wdata_q <= mrg_word;
      end
      if (ld_merge) held_q  <= t_rdata;
      if (ld_rdata) rdata_q <= rdata_d;
    end
  end

  assign t_valid    = (state_q == ST_PASS) || (state_q == ST_RD) || (state_q == ST_WR);
  assign t_write    = (state_q == ST_WR) || ((state_q == ST_PASS) && write_q);
  assign t_lock     = alias_q && write_q && ((state_q == ST_RD) || (state_q == ST_WR));
  assign t_addr     = addr_q;
  assign t_size     = size_q;
  assign t_wdata    = wdata_q;
  assign m_ready    = (state_q == ST_RESP);
  assign m_rdata    = rdata_q;
  assign m_err      = err_q;
  assign sel_bitpos = bitpos_q;
  assign sel_wbit   = wbit_q;
  assign held_word  = held_q;

  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready);

  assert_tgt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && !t_ready) |=> (t_valid && $stable(t_addr) && $stable(t_write)));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && m_err) |-> (m_rdata == '0 && !$past(t_valid)));

  assert_rmw_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_valid && t_write && t_lock) |->
      ($past(t_valid && !t_write && t_lock && t_ready) && t_addr == $past(t_addr)));

  assert_alias_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ready && alias_q && !write_q) |-> (m_rdata[DW-1:1] == '0));

endmodule

// File: rtl/bb_bridge.sv
module bb_bridge
  import bb_pkg::*;
#(
  parameter int unsigned NREG        = 2,
  parameter logic [NREG*32-1:0] REGION_BASE = {32'h4000_0000, 32'h2000_0000},
  parameter logic [NREG*32-1:0] REGION_SIZE = {32'h0010_0000, 32'h0000_8000},
  parameter logic [31:0] ALIAS_OFS   = 32'h0200_0000,
  parameter logic [31:0] ALIAS_SPAN  = 32'h0200_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_valid,
  input  logic              m_write,
  input  logic [BB_AW-1:0]  m_addr,
  input  logic [1:0]        m_size,
  input  logic [BB_DW-1:0]  m_wdata,
  output logic              m_ready,
  output logic [BB_DW-1:0]  m_rdata,
  output logic              m_err,
  output logic              t_valid,
  output logic              t_write,
  output logic              t_lock,
  output logic [BB_AW-1:0]  t_addr,
  output logic [1:0]        t_size,
  output logic [BB_DW-1:0]  t_wdata,
  input  logic              t_ready,
  input  logic [BB_DW-1:0]  t_rdata
);

  localparam int unsigned AW = BB_AW;
  localparam int unsigned DW = BB_DW;
  localparam int unsigned BW = BB_BW;

  logic rst_n_s;

  bb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  logic [NREG-1:0]         hit_v, err_v;
  logic [NREG-1:0][AW-1:0] taddr_v;
  logic [NREG-1:0][BW-1:0] bpos_v;

  for (genvar r = 0; r < NREG; r++) begin : g_region
    bb_region_dec #(
      .AW(AW), .BW(BW),
      .BASE(REGION_BASE[r*32 +: 32]),
      .SIZE(REGION_SIZE[r*32 +: 32]),
      .ALIAS_OFS(ALIAS_OFS),
      .ALIAS_SPAN(ALIAS_SPAN)
    ) u_dec (
      .addr_w(m_addr[AW-1:2]), .size(m_size),
      .hit(hit_v[r]), .err(err_v[r]),
      .taddr(taddr_v[r]), .bitpos(bpos_v[r])
    );
  end

  logic          dec_hit, dec_err;
  logic [AW-1:0] dec_taddr;
  logic [BW-1:0] dec_bitpos;

  always_comb begin
    dec_hit    = |hit_v;
    dec_err    = |err_v;
    dec_taddr  = '0;
    dec_bitpos = '0;
    for (int r = 0; r < NREG; r++) begin
      if (hit_v[r] || err_v[r]) begin
        dec_taddr  = taddr_v[r];
        dec_bitpos = bpos_v[r];
      end
    end
  end

  logic [DW-1:0] mrg_word, held_word;
  logic          mrg_bit, sel_wbit;
  logic [BW-1:0] sel_bitpos;

  bb_bit_merge #(.DW(DW), .BW(BW)) u_merge (
    .rword(t_rdata), .bitpos(sel_bitpos), .wbit(sel_wbit),
    .mword(mrg_word), .rbit(mrg_bit)
  );

  bb_rmw_seq #(.AW(AW), .DW(DW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata),
    .dec_hit(dec_hit), .dec_err(dec_err),
    .dec_taddr(dec_taddr), .dec_bitpos(dec_bitpos),
    .t_ready(t_ready), .t_rdata(t_rdata),
    .mrg_word(mrg_word), .mrg_bit(mrg_bit),
    .t_valid(t_valid), .t_write(t_write), .t_lock(t_lock),
    .t_addr(t_addr), .t_size(t_size), .t_wdata(t_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .sel_bitpos(sel_bitpos), .sel_wbit(sel_wbit), .held_word(held_word)
  );

  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (t_valid && t_write && t_lock) |-> ($countones(t_wdata ^ held_word) <= 1));

  assert_bit_value_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (t_valid && t_write && t_lock) |-> (t_wdata[sel_bitpos] == sel_wbit));

  assert_lock_scope_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    t_lock |-> t_valid);

  assert_one_window_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(hit_v | err_v));

endmodule

// File: tb/tb_bb_bridge.sv
module tb_bb_bridge;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m_valid, m_write;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic        m_ready, m_err;
  logic [31:0] m_rdata;
  logic        t_valid, t_write, t_lock, t_ready;
  logic [31:0] t_addr, t_wdata, t_rdata;
  logic [1:0]  t_size;

  always #2 clk = ~clk; // 250 MHz

  bb_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .t_valid(t_valid), .t_write(t_write), .t_lock(t_lock),
    .t_addr(t_addr), .t_size(t_size), .t_wdata(t_wdata),
    .t_ready(t_ready), .t_rdata(t_rdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- target memory model ----------------
  logic [31:0] tmem   [512];
  logic [31:0] shadow [512];
  int          wait_cfg = 0;
  int          wait_q;

  function automatic int midx(input logic [31:0] a);
    return int'({a[30], a[9:2]});
  endfunction

  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd2) return 4'hF;
    if (sz == 2'd1) return lo[1] ? 4'hC : 4'h3;
    return 4'b0001 << lo;
  endfunction

  assign t_ready = t_valid && (wait_q == 0);
  assign t_rdata = tmem[midx(t_addr)];

  always @(posedge clk) begin
    if (!t_valid || t_ready) wait_q <= wait_cfg;
    else                     wait_q <= wait_q - 1;
    if (t_valid && t_ready && t_write) begin
      for (int k = 0; k < 4; k++)
        if (lanes(t_size, t_addr[1:0])[k]) tmem[midx(t_addr)][k*8 +: 8] <= t_wdata[k*8 +: 8];
    end
  end

  // ---------------- target-side observer ----------------
  int          tacc = 0;
  int          twr  = 0;
  logic [31:0] last_taddr;
  logic [1:0]  last_tsize;
  logic        prev_lrd = 1'b0;
  logic [31:0] prev_addr;
  logic        go = 1'b0;

  always @(negedge clk) begin
    if (go && t_valid && t_ready) begin
      tacc++;
      last_taddr = t_addr;
      last_tsize = t_size;
      if (t_write) twr++;
      if (t_write && t_lock)
        chk(prev_lrd && prev_addr == t_addr, "R6 locked write follows locked read of same word",
            prev_addr, t_addr);
      prev_lrd  = !t_write && t_lock;
      prev_addr = t_addr;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [31:0] rdata;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always @(negedge clk) begin
    if (go && m_ready) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R9 unexpected m_ready pulse", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(m_rdata == e.rdata, {e.tag, " rdata"}, m_rdata, e.rdata);
        chk(m_err == e.err, {e.tag, " err"}, {31'd0, m_err}, {31'd0, e.err});
      end
    end
  end

  // ---------------- driver ----------------
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic do_req(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [1:0] sz, input logic [31:0] er, input logic ee,
                        input string tag);
    exp_t e;
    e.rdata = er; e.err = ee; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_addr = a; m_wdata = wd; m_size = sz;
    for (int w = 0; w < 200; w++) begin
      @(negedge clk);
      if (m_ready) break;
    end
    m_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] alias_of(input logic [31:0] base, input int o, input int b);
    return base + 32'h0200_0000 + 32'(o) * 32 + 32'(b) * 4;
  endfunction

  function automatic logic [31:0] align(input logic [31:0] a, input logic [1:0] sz);
    if (sz == 2'd2) return {a[31:2], 2'b00};
    if (sz == 2'd1) return {a[31:1], 1'b0};
    return a;
  endfunction

  task automatic pass_rd(input logic [31:0] a, input string tag);
    do_req(1'b0, a, 32'h0, 2'd2, shadow[midx(a)], 1'b0, tag);
  endtask

  task automatic pass_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
    do_req(1'b1, a, d, 2'd2, 32'h0, 1'b0, tag);
    shadow[midx(a)] = d;
  endtask

  task automatic alias_wr(input logic [31:0] base, input int o, input int b,
                          input logic [1:0] sz, input logic [31:0] wd, input string tag);
    int p;
    logic [31:0] ta;
    p  = (o % 4) * 8 + b;
    ta = align(base + 32'(o), sz);
    do_req(1'b1, alias_of(base, o, b), wd, sz, 32'h0, 1'b0, tag);
    shadow[midx(ta)][p] = wd[0];
    chk(last_taddr == ta, {tag, " target address"}, last_taddr, ta);
    chk(last_tsize == sz, {tag, " target size"}, {30'd0, last_tsize}, {30'd0, sz});
  endtask

  task automatic alias_rd(input logic [31:0] base, input int o, input int b,
                          input logic [1:0] sz, input string tag);
    int p;
    int w0;
    logic [31:0] ta;
    p  = (o % 4) * 8 + b;
    ta = align(base + 32'(o), sz);
    w0 = twr;
    do_req(1'b0, alias_of(base, o, b), 32'hFFFF_FFFF, sz, {31'd0, shadow[midx(ta)][p]}, 1'b0, tag);
    chk(twr == w0, {tag, " no target write"}, 32'(twr), 32'(w0));
    chk(last_taddr == ta, {tag, " target address"}, last_taddr, ta);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #400000;
    chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    for (int i = 0; i < 512; i++) begin
      tmem[i]   = {i[7:0], 8'h5A, ~i[7:0], 8'hC3};
      shadow[i] = {i[7:0], 8'h5A, ~i[7:0], 8'hC3};
    end
    m_valid = 1'b0; m_write = 1'b0; m_addr = '0; m_wdata = '0; m_size = 2'd2;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R10: quiet outputs in reset
    chk(!m_ready && !m_err, "R10 master side idle in reset", {31'd0, m_ready}, 32'd0);
    chk(!t_valid && !t_lock, "R10 target side idle in reset", {31'd0, t_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!m_ready && !t_valid && !t_lock && !m_err, "R10 idle after reset", {31'd0, t_valid}, 32'd0);
    go = 1'b1;

    // R1: passthrough
    pass_rd(32'h2000_0010, "R1 passthrough read region0");
    chk(last_taddr == 32'h2000_0010, "R1 passthrough address", last_taddr, 32'h2000_0010);
    pass_wr(32'h4000_0020, 32'h1234_5678, "R1 passthrough write");
    pass_rd(32'h4000_0020, "R1 passthrough readback");

    // R2/R3/R4: alias set, word size
    alias_wr(32'h2000_0000, 'h11, 3, 2'd2, 32'h0000_0001, "R2 alias set bit 11");
    pass_rd(32'h2000_0010, "R4 neighbours kept after set");
    // R3: clear with upper write-data bits high (ignored)
    alias_wr(32'h2000_0000, 'h10, 1, 2'd2, 32'hFFFF_FFFE, "R3 clear ignores upper bits");
    pass_rd(32'h2000_0010, "R3 bit cleared, R4 rest kept");
    alias_wr(32'h2000_0000, 'h10, 6, 2'd2, 32'hFFFF_FFFF, "R3 set bit 6");
    pass_rd(32'h2000_0010, "R3 bit 6 set");

    // R5: alias reads, both values
    alias_rd(32'h2000_0000, 'h11, 3, 2'd2, "R5 alias read one");
    alias_rd(32'h2000_0000, 'h10, 1, 2'd2, "R5 alias read zero");

    // R2: second region, top bit of word
    alias_wr(32'h4000_0000, 'h23, 7, 2'd2, 32'h1, "R2 region1 bit 31");
    pass_rd(32'h4000_0020, "R4 region1 word after set");
    alias_rd(32'h4000_0000, 'h23, 7, 2'd2, "R5 region1 bit 31 read");

    // R7: size carried, halfword and byte
    alias_wr(32'h2000_0000, 'h12, 1, 2'd1, 32'h0, "R7 halfword alias clear");
    alias_wr(32'h2000_0000, 'h13, 6, 2'd0, 32'h1, "R7 byte alias set");
    pass_rd(32'h2000_0010, "R7 word after narrow alias writes");

    // R8: beyond region size
    begin
      int a0;
      a0 = tacc;
      do_req(1'b1, alias_of(32'h2000_0000, 'h8000, 0), 32'h1, 2'd2, 32'h0, 1'b1, "R8 write beyond region");
      do_req(1'b0, alias_of(32'h2000_0000, 'h9000, 5), 32'h0, 2'd2, 32'h0, 1'b1, "R8 read beyond region");
      chk(tacc == a0, "R8 no target access on error", 32'(tacc), 32'(a0));
      pass_rd(32'h2000_0000, "R8 memory untouched");
    end

    // R9: target wait states
    wait_cfg = 2;
    alias_wr(32'h4000_0000, 'h04, 2, 2'd2, 32'h1, "R9 alias set with wait states");
    alias_rd(32'h4000_0000, 'h04, 2, 2'd2, "R9 alias read with wait states");
    pass_rd(32'h4000_0004, "R9 passthrough with wait states");
    wait_cfg = 0;

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R9 one response per request", 32'(sbq.size()), 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule